// File: doc/BRIEF.md
# Packed Byte Data Buffer

A four-byte shift buffer between a 16-bit host data register and a byte-wide serial bus engine. The host appends transmit data with 16-bit or 8-bit writes and drains receive data with 16-bit reads. The engine pops transmit bytes from the most recently shifted end of the buffer, and it deposits received bytes into successively higher byte lanes. A big-endian control input selects whether the two bytes of a 16-bit host access are swapped.

The block keeps separate transmit and receive byte counts. It maintains these status flags: transmit underflow, receive overrun, transmit ready, receive ready and single-byte data. The engine sets the underflow, overrun and transmit-ready flags. Host accesses clear them. After every host access the block issues a one-cycle kick strobe so that the engine moves more bytes. When a read empties the receive side while the controller is in master-receive mode, the block pulses a finish output. The surrounding logic uses that pulse to raise access-ready and leave master mode.

Top module: `byte_pack_buf`

## Requirements
- R1: After reset, both counts are 0, all five status flags are 0, and the kick and finish outputs are 0.
- R2: A 16-bit write with tx_count at most 2 adds 2 to tx_count. With big_endian low, the low byte of wr_data goes to lane 1 and the high byte goes to lane 0. Lane n is buffer bits [8n+7:8n].
- R3: With big_endian high, a 16-bit write places wr_data[15:8] in lane 1 and wr_data[7:0] in lane 0.
- R4: A 16-bit or 8-bit write made while tx_count exceeds 2 is dropped. It leaves tx_count and the buffer contents unchanged.
- R5: An 8-bit write with tx_count at most 2 shifts the buffer up one lane, places wr_data[7:0] in lane 0 and adds 1 to tx_count.
- R6: An accepted write clears tx_underflow. If tx_count then exceeds 2, the write also clears tx_ready. Both clears take priority over a set request in the same cycle.
- R7: tx_byte shows lane (tx_count−1). A tx_pop with tx_count non-zero decrements tx_count.
- R8: An rx_push with rx_count below 4 writes rx_byte into lane rx_count, increments rx_count, sets rx_ready and clears single_byte. An rx_push at rx_count 4 is ignored.
- R9: rd_data is {lane1, lane0} with big_endian low and {lane0, lane1} with big_endian high.
- R10: A read at rx_count 1 sets single_byte and sets rx_count to 0. A read at rx_count 2 subtracts 2 without shifting. A read at rx_count 3 or 4 shifts the buffer down two lanes and subtracts 2.
- R11: A read that leaves rx_count at 0 clears rx_ready and pulses rx_finish for one cycle, but only if master_rx is high.
- R12: Every read clears rx_overrun, and the clear takes priority over a set in the same cycle.
- R13: kick is high for exactly the one cycle after each host read or write, including a dropped write.
- R14: Host accesses have priority in the order wr16, wr8, rd16. A cycle with any host access ignores tx_pop and rx_push.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| big_endian | input | 1 | Disables the byte swap on host accesses |
| master_rx | input | 1 | Controller is in master-receive mode |
| wr16_en | input | 1 | Host 16-bit data write |
| wr8_en | input | 1 | Host 8-bit data write |
| wr_data | input | 16 | Host write data |
| rd16_en | input | 1 | Host 16-bit data read (consumes) |
| rd_data | output | 16 | Host read data |
| tx_pop | input | 1 | Engine takes one transmit byte |
| tx_byte | output | 8 | Next transmit byte |
| rx_push | input | 1 | Engine delivers one received byte |
| rx_byte | input | 8 | Received byte |
| txudf_set | input | 1 | Engine reports a transmit underflow |
| rovr_set | input | 1 | Engine reports a receive overrun |
| txrdy_set | input | 1 | Engine requests more transmit data |
| tx_count | output | 3 | Pending transmit bytes (0..4) |
| rx_count | output | 3 | Held receive bytes (0..4) |
| tx_underflow | output | 1 | Transmit underflow flag |
| rx_overrun | output | 1 | Receive overrun flag |
| tx_ready | output | 1 | Transmit ready flag |
| rx_ready | output | 1 | Receive ready flag |
| single_byte | output | 1 | Last read returned a single byte |
| kick | output | 1 | One-cycle strobe after a host access |
| rx_finish | output | 1 | Read emptied receive side in master-receive mode |

## Verification
The assertions check the following on every cycle: both counts stay within 0 to 4, an over-full write leaves tx_count unchanged, accepted writes clear underflow, reads clear overrun, a one-byte read sets single_byte, a lone pop decrements tx_count, and kick and rx_finish appear only after their causes. The bench scenarios are needed to show the byte placement, which depends on data values across several operations. That covers the lane swap under each endian setting, the order in which popped bytes come out after mixed 16-bit and 8-bit writes, the downward shift on reads, and the fact that a dropped write leaves the buffer contents intact.

// File: rtl/byte_pack_buf.sv
module byte_pack_buf (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        big_endian,
  input  logic        master_rx,
  input  logic        wr16_en,
  input  logic        wr8_en,
  input  logic [15:0] wr_data,
  input  logic        rd16_en,
  output logic [15:0] rd_data,
  input  logic        tx_pop,
  output logic [7:0]  tx_byte,
  input  logic        rx_push,
  input  logic [7:0]  rx_byte,
  input  logic        txudf_set,
  input  logic        rovr_set,
  input  logic        txrdy_set,
  output logic [2:0]  tx_count,
  output logic [2:0]  rx_count,
  output logic        tx_underflow,
  output logic        rx_overrun,
  output logic        tx_ready,
  output logic        rx_ready,
  output logic        single_byte,
  output logic        kick,
  output logic        rx_finish
);
  logic [31:0] buf_q;
  logic [2:0]  txl, rxl, txl_m1;
  logic        host, tx_room;
  logic [15:0] wword;

  assign host    = wr16_en | wr8_en | rd16_en;
  assign tx_room = (txl <= 3'd2);
  assign wword   = big_endian ? wr_data : {wr_data[7:0], wr_data[15:8]};
  assign txl_m1  = txl - 3'd1;
  assign tx_byte = buf_q[{txl_m1[1:0], 3'b000} +: 8];
  assign rd_data = big_endian ? {buf_q[7:0], buf_q[15:8]} : buf_q[15:0];
  assign tx_count = txl;
  assign rx_count = rxl;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      buf_q        <= '0;
      txl          <= '0;
      rxl          <= '0;
      tx_underflow <= 1'b0;
      rx_overrun   <= 1'b0;
      tx_ready     <= 1'b0;
      rx_ready     <= 1'b0;
      single_byte  <= 1'b0;
      kick         <= 1'b0;
      rx_finish    <= 1'b0;
    end else begin
      kick      <= host;
      rx_finish <= 1'b0;
      if (txudf_set) tx_underflow <= 1'b1;
      if (rovr_set)  rx_overrun   <= 1'b1;
      if (txrdy_set) tx_ready     <= 1'b1;
      if (wr16_en) begin
        if (tx_room) begin
          buf_q        <= {buf_q[15:0], wword};
          txl          <= txl + 3'd2;
          tx_underflow <= 1'b0;
          if (txl != 3'd0) tx_ready <= 1'b0;
        end
      end else if (wr8_en) begin
        if (tx_room) begin
          buf_q        <= {buf_q[23:0], wr_data[7:0]};
          txl          <= txl + 3'd1;
          tx_underflow <= 1'b0;
          if (txl == 3'd2) tx_ready <= 1'b0;
        end
      end else if (rd16_en) begin
        rx_overrun <= 1'b0;
        if (rxl == 3'd1) single_byte <= 1'b1;
        if (rxl > 3'd2) buf_q <= {16'h0000, buf_q[31:16]};
        if (rxl > 3'd1) rxl <= rxl - 3'd2;
        else            rxl <= 3'd0;
        if (rxl <= 3'd2) begin
          rx_ready  <= 1'b0;
          rx_finish <= master_rx;
        end
      end else begin
        if (tx_pop && txl != 3'd0) txl <= txl_m1;
        if (rx_push && rxl < 3'd4) begin
          buf_q[{rxl[1:0], 3'b000} +: 8] <= rx_byte;
          rxl         <= rxl + 3'd1;
          rx_ready    <= 1'b1;
          single_byte <= 1'b0;
        end
      end
    end
  end
endmodule

module byte_pack_buf_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       wr16_en,
  input logic       wr8_en,
  input logic       rd16_en,
  input logic       tx_pop,
  input logic       rx_push,
  input logic       master_rx,
  input logic [2:0] tx_count,
  input logic [2:0] rx_count,
  input logic       tx_underflow,
  input logic       rx_overrun,
  input logic       single_byte,
  input logic       kick,
  input logic       rx_finish
);
  p_len_bound_r8: assert property (@(posedge clk) disable iff (!rst_n)
    tx_count <= 3'd4 && rx_count <= 3'd4);
  p_drop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (wr16_en || wr8_en) && tx_count > 3'd2 |=> $stable(tx_count));
  p_udf_clear_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr16_en || wr8_en) && tx_count <= 3'd2 |=> !tx_underflow);
  p_pop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    tx_pop && !(wr16_en || wr8_en || rd16_en) && tx_count != 3'd0
    |=> tx_count == $past(tx_count) - 3'd1);
  p_sbd_r10: assert property (@(posedge clk) disable iff (!rst_n)
    rd16_en && !wr16_en && !wr8_en && rx_count == 3'd1 |=> single_byte && rx_count == 3'd0);
  p_finish_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_finish) |-> $past(rd16_en) && $past(master_rx));
  p_rovr_r12: assert property (@(posedge clk) disable iff (!rst_n)
    rd16_en && !wr16_en && !wr8_en |=> !rx_overrun);
  p_kick_r13: assert property (@(posedge clk) disable iff (!rst_n)
    (wr16_en || wr8_en || rd16_en) |=> kick);
  p_push_block_r14: assert property (@(posedge clk) disable iff (!rst_n)
    rx_push && (wr16_en || wr8_en) |=> $stable(rx_count));
endmodule

bind byte_pack_buf byte_pack_buf_chk u_chk (.*);

// File: tb/byte_pack_buf_bench.sv
`timescale 1ns/1ps
module byte_pack_buf_bench;
  logic clk = 0, rst_n = 0;
  logic big_endian = 0, master_rx = 0, wr16_en = 0, wr8_en = 0, rd16_en = 0;
  logic [15:0] wr_data = 0, rd_data;
  logic tx_pop = 0, rx_push = 0, txudf_set = 0, rovr_set = 0, txrdy_set = 0;
  logic [7:0] rx_byte = 0, tx_byte;
  logic [2:0] tx_count, rx_count;
  logic tx_underflow, rx_overrun, tx_ready, rx_ready, single_byte, kick, rx_finish;
  int checks = 0, errors = 0;
  bit done = 0;

  always #4 clk = ~clk;

  byte_pack_buf u_byte_pack_buf (.*);

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic step(); @(negedge clk); endtask

  task automatic w16(input logic be, input logic [15:0] d);
    big_endian = be; wr_data = d; wr16_en = 1; step(); wr16_en = 0;
  endtask
  task automatic w8(input logic [7:0] d);
    wr_data = {8'h00, d}; wr8_en = 1; step(); wr8_en = 0;
  endtask
  task automatic pop(input string req, input logic [7:0] exp);
    tx_pop = 1; chk(req, tx_byte, exp); step(); tx_pop = 0;
  endtask
  task automatic push(input logic [7:0] b);
    rx_byte = b; rx_push = 1; step(); rx_push = 0;
  endtask
  task automatic rd(input string req, input logic be, input logic [15:0] exp);
    big_endian = be; rd16_en = 1; #1; chk(req, rd_data, exp); step(); rd16_en = 0;
  endtask

  // {big_endian, word, first popped byte, second popped byte}
  localparam logic [32:0] VEC [4] = '{
    {1'b0, 16'hAABB, 8'hBB, 8'hAA},
    {1'b1, 16'hAABB, 8'hAA, 8'hBB},
    {1'b0, 16'h1234, 8'h34, 8'h12},
    {1'b1, 16'h5A0F, 8'h5A, 8'h0F}
  };

  initial begin
    #(8 * 100000);
    if (!done) begin
      errors++;
      checks++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    step(); step(); rst_n = 1; step();
    chk("R1 tx_count", tx_count, 0);
    chk("R1 rx_count", rx_count, 0);
    chk("R1 flags", {tx_underflow, rx_overrun, tx_ready, rx_ready, single_byte, kick, rx_finish}, 0);

    for (int i = 0; i < 4; i++) begin
      w16(VEC[i][32], VEC[i][31:16]);
      chk("R2 count", tx_count, 2);
      pop(VEC[i][32] ? "R3 lane1" : "R2 lane1", VEC[i][15:8]);
      pop(VEC[i][32] ? "R3 lane0" : "R2 lane0", VEC[i][7:0]);
      chk("R7 drained", tx_count, 0);
    end

    // R5, R4, R6 mixed writes
    txudf_set = 1; txrdy_set = 1; step(); txudf_set = 0; txrdy_set = 0;
    w16(0, 16'h1122);
    chk("R6 udf cleared", tx_underflow, 0);
    chk("R6 ready kept at 2", tx_ready, 1);
    chk("R13 kick", kick, 1);
    w8(8'h33);
    chk("R5 count", tx_count, 3);
    chk("R6 ready cleared", tx_ready, 0);
    step();
    chk("R13 kick one cycle", kick, 0);
    txudf_set = 1; step(); txudf_set = 0;
    w16(0, 16'hDEAD);
    chk("R4 dropped count", tx_count, 3);
    chk("R4 dropped udf kept", tx_underflow, 1);
    chk("R13 kick on dropped", kick, 1);
    w8(8'h77);
    chk("R4 dropped w8", tx_count, 3);
    pop("R7 lane2", 8'h22);
    pop("R7 lane1", 8'h11);
    pop("R5 lane0", 8'h33);

    // R14 write wins over pop
    tx_pop = 1; w16(1, 16'h0102); tx_pop = 0;
    chk("R14 pop ignored", tx_count, 2);
    pop("R14 lane1", 8'h01);
    pop("R14 lane0", 8'h02);

    // R8 receive fill and R10 shift
    push(8'hA0); push(8'hA1); push(8'hA2); push(8'hA3);
    chk("R8 rx_ready", rx_ready, 1);
    push(8'hFF);
    chk("R8 full ignored", rx_count, 4);
    master_rx = 1;
    rovr_set = 1; step(); rovr_set = 0;
    rd("R9 first", 0, 16'hA1A0);
    chk("R12 rovr cleared", rx_overrun, 0);
    chk("R10 count", rx_count, 2);
    chk("R11 no finish yet", rx_finish, 0);
    rd("R10 shifted", 0, 16'hA3A2);
    chk("R11 empty", rx_count, 0);
    chk("R11 rx_ready", rx_ready, 0);
    chk("R11 finish", rx_finish, 1);
    step();
    chk("R11 finish one cycle", rx_finish, 0);
    master_rx = 0;

    // R10 odd byte
    push(8'hB0); push(8'hB1); push(8'hB2);
    rd("R9 odd first", 0, 16'hB1B0);
    chk("R10 count after 3", rx_count, 1);
    rd("R10 single", 0, 16'h00B2);
    chk("R10 sbd", single_byte, 1);
    chk("R10 empty", rx_count, 0);
    chk("R11 no finish w/o master", rx_finish, 0);
    push(8'hC0);
    chk("R8 sbd cleared", single_byte, 0);
    push(8'hC1);
    rd("R9 big endian read", 1, 16'hC0C1);

    // R14 read wins over push
    push(8'h10); push(8'h20); push(8'h30);
    rx_byte = 8'h99; rx_push = 1; rd("R14 read", 0, 16'h2010); rx_push = 0;
    chk("R14 push ignored", rx_count, 1);
    rd("R14 remaining", 0, 16'h0030);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule